// File: doc/BRIEF.md
# Transfer Count and Completion Controller

This block does the per-transfer bookkeeping of an interrupt-triggered data transfer engine. Each time the engine reports a finished transfer on `done_i`, the block updates a 16-bit transfer count. It decides whether the programmed run is over. It then issues one of three outcomes: a CPU interrupt request, a pulse that clears the activation source flag, or a pulse that continues a chain to the next descriptor.

In linear mode the whole count register counts down. A loaded value of zero stands for 65,536 transfers. In the split modes the upper byte holds the programmed length and the lower byte is the working counter, which reloads from the upper byte. A split-mode run never ends.

A chain-enable input turns off end detection and flag clearing. An interrupt-select input asks for an interrupt after every transfer rather than only at the end. For word-size transfers the block also reports a source or destination address that is odd.

Software or a descriptor fetcher writes the count through `load_en`/`load_count`. Every outcome is a single-cycle pulse in the cycle after the strobe.

Top module: `xfer_count_ctrl`

## Requirements
- R1: While `rst` is high at a rising edge, `count_o` becomes 0 and every pulse output becomes 0 from the next cycle on.
- R2: When `load_en` is 1, `count_o` shows `load_count` one cycle later, and this replaces any count update from `done_i` in the same cycle.
- R3: With `mode_i` = 00 (linear), a `done_i` without load lowers `count_o` by one one cycle later, and 0 wraps to FFFF. Without `done_i` or `load_en`, `count_o` holds its value.
- R4: With `mode_i` = 00, `chain_en` = 0 and `count_o` = 1 at the strobe, `end_o`, `irq_o` and `clr_en_o` pulse together one cycle later and `clr_src_o` stays low. A load of 0 therefore ends after exactly 65,536 strobes.
- R5: With `mode_i` other than 00, a strobe leaves `count_o[15:8]` unchanged and lowers `count_o[7:0]` by one. If the lower byte is 1 it reloads it from the upper byte, and if it is 0 it goes to FF. `end_o` and `clr_en_o` never pulse in this mode.
- R6: A strobe with `chain_en` = 1 pulses `chain_o` one cycle later and keeps `end_o`, `irq_o`, `clr_src_o` and `clr_en_o` low. The count is still updated.
- R7: A strobe with `chain_en` = 0, `irq_sel` = 1 and no end pulses `irq_o` one cycle later with `clr_src_o` low.
- R8: A strobe with `chain_en` = 0, `irq_sel` = 0 and no end pulses `clr_src_o` one cycle later with `irq_o` low.
- R9: A strobe with `word_size` = 1 and bit 0 of `src_addr` or `dst_addr` set pulses `addr_err_o` one cycle later. The pulse does not depend on the chain and interrupt inputs. It stays low for byte transfers or even addresses.
- R10: Every pulse output is high for one cycle only, and only in the cycle right after a cycle with `done_i` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| load_en | input | 1 | Write `load_count` into the count register |
| load_count | input | 16 | Value to load |
| mode_i | input | 2 | 00 linear, any other value split (ring/block) |
| chain_en | input | 1 | Continue with the next descriptor instead of completing |
| irq_sel | input | 1 | 1: interrupt after every transfer; 0: only at the end |
| word_size | input | 1 | 1: the current transfer is word-sized |
| src_addr | input | 24 | Source address of the current transfer |
| dst_addr | input | 24 | Destination address of the current transfer |
| done_i | input | 1 | One transfer has completed |
| count_o | output | 16 | Current transfer count |
| end_o | output | 1 | Pulse: programmed run has finished |
| irq_o | output | 1 | Pulse: CPU interrupt request |
| clr_src_o | output | 1 | Pulse: clear the activation source flag |
| clr_en_o | output | 1 | Pulse: clear the controller enable bit |
| chain_o | output | 1 | Pulse: fetch the next chained descriptor |
| addr_err_o | output | 1 | Pulse: word transfer with an odd address |

## Verification
The bench loads zero in linear mode and strobes it 65,536 times. A design that treats zero as "already done" would end at once, and one that stops at FFFF would never end. It loads counts of 1 with chain enable set and with it clear. This catches a design that signals end or clears flags during a chain, and one that lets a load lose to a simultaneous strobe. In split mode it drives the lower byte through 1 and through 0. A wrong reload would corrupt the upper byte or wrap to zero instead of to the programmed length. Random traffic mixes odd addresses with byte and word sizes, so an alignment check that ignores the size or one of the two addresses shows up.

// File: rtl/xcc_pkg.sv
package xcc_pkg;

    typedef enum logic [1:0] {
        XM_LINEAR = 2'b00,
        XM_RING   = 2'b01,
        XM_BLOCK  = 2'b10,
        XM_SPARE  = 2'b11
    } xfer_mode_e;

    typedef struct packed {
        logic fin;
        logic irq;
        logic clr_src;
        logic clr_en;
        logic chain;
        logic addr_err;
    } pulse_t;

endpackage

// File: rtl/xcc_count_step.sv
module xcc_count_step #(
    parameter int CNT_W = 16
) (
    input  logic [CNT_W-1:0] cnt,
    input  logic             split,
    output logic [CNT_W-1:0] cnt_next,
    output logic             last
);
    localparam int HALF_W = CNT_W / 2;

    logic [HALF_W-1:0] hi;
    logic [HALF_W-1:0] lo;
    logic [HALF_W-1:0] lo_next;

    assign hi = cnt[CNT_W-1:HALF_W];
    assign lo = cnt[HALF_W-1:0];

    always_comb begin
        // the working byte reloads from the programmed length when it expires
        if (lo == HALF_W'(1)) begin
            lo_next = hi;
        end else begin
            lo_next = lo - 1'b1;
        end
        if (split) begin
            cnt_next = {hi, lo_next};
            last     = 1'b0;
        end else begin
            cnt_next = cnt - 1'b1;
            last     = (cnt == CNT_W'(1));
        end
    end
endmodule

// File: rtl/xcc_align_chk.sv
module xcc_align_chk #(
    parameter int ADDR_W = 24
) (
    input  logic              word,
    input  logic [ADDR_W-1:0] src,
    input  logic [ADDR_W-1:0] dst,
    output logic              bad
);
    logic unused_addr_hi;
    assign unused_addr_hi = ^{src[ADDR_W-1:1], dst[ADDR_W-1:1]};
    assign bad = word & (src[0] | dst[0]);
endmodule

// File: rtl/xcc_resolve.sv
module xcc_resolve
    import xcc_pkg::*;
(
    input  logic   fire,
    input  logic   chain,
    input  logic   every,
    input  logic   last,
    input  logic   bad_align,
    output pulse_t pulses
);
    always_comb begin
        pulses = '0;
        if (fire) begin
            pulses.addr_err = bad_align;
            if (chain) begin
                pulses.chain = 1'b1;
            end else if (last) begin
                pulses.fin    = 1'b1;
                pulses.irq    = 1'b1;
                pulses.clr_en = 1'b1;
            end else if (every) begin
                pulses.irq = 1'b1;
            end else begin
                pulses.clr_src = 1'b1;
            end
        end
    end
endmodule

// File: rtl/xfer_count_ctrl.sv
module xfer_count_ctrl
    import xcc_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_en,
    input  logic [CNT_W-1:0]  load_count,
    input  logic [1:0]        mode_i,
    input  logic              chain_en,
    input  logic              irq_sel,
    input  logic              word_size,
    input  logic [ADDR_W-1:0] src_addr,
    input  logic [ADDR_W-1:0] dst_addr,
    input  logic              done_i,
    output logic [CNT_W-1:0]  count_o,
    output logic              end_o,
    output logic              irq_o,
    output logic              clr_src_o,
    output logic              clr_en_o,
    output logic              chain_o,
    output logic              addr_err_o
);
    typedef struct packed {
        logic [CNT_W-1:0] count;
        pulse_t           p;
    } state_t;

    state_t           st_d;
    state_t           st_q;
    logic [CNT_W-1:0] cnt_next;
    logic             at_last;
    logic             bad_align;
    logic             split_mode;
    pulse_t           pulses;

    assign split_mode = (xfer_mode_e'(mode_i) != XM_LINEAR);

    xcc_count_step #(.CNT_W(CNT_W)) u_step (
        .cnt      (st_q.count),
        .split    (split_mode),
        .cnt_next (cnt_next),
        .last     (at_last)
    );

    xcc_align_chk #(.ADDR_W(ADDR_W)) u_align (
        .word (word_size),
        .src  (src_addr),
        .dst  (dst_addr),
        .bad  (bad_align)
    );

    xcc_resolve u_resolve (
        .fire      (done_i),
        .chain     (chain_en),
        .every     (irq_sel),
        .last      (at_last),
        .bad_align (bad_align),
        .pulses    (pulses)
    );

    always_comb begin
        st_d   = st_q;
        st_d.p = pulses;
        if (done_i) begin
            st_d.count = cnt_next;
        end
        if (load_en) begin
            st_d.count = load_count;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count_o    = st_q.count;
    assign end_o      = st_q.p.fin;
    assign irq_o      = st_q.p.irq;
    assign clr_src_o  = st_q.p.clr_src;
    assign clr_en_o   = st_q.p.clr_en;
    assign chain_o    = st_q.p.chain;
    assign addr_err_o = st_q.p.addr_err;
endmodule

// File: rtl/xcc_checker.sv
module xcc_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             load_en,
    input logic [CNT_W-1:0] load_count,
    input logic [1:0]       mode_i,
    input logic             done_i,
    input logic [CNT_W-1:0] count_o,
    input logic             end_o,
    input logic             irq_o,
    input logic             clr_src_o,
    input logic             clr_en_o,
    input logic             chain_o,
    input logic             addr_err_o
);
    localparam int HALF_W = CNT_W / 2;

    a_r2_load_wins: assert property (@(posedge clk) disable iff (rst)
        load_en |=> count_o == $past(load_count));

    a_r3_hold: assert property (@(posedge clk) disable iff (rst)
        (!done_i && !load_en) |=> $stable(count_o));

    a_r3_decrement: assert property (@(posedge clk) disable iff (rst)
        (done_i && !load_en && mode_i == 2'b00) |=> count_o == $past(count_o) - 1'b1);

    a_r4_end_outcome: assert property (@(posedge clk) disable iff (rst)
        end_o |-> (irq_o && clr_en_o && !clr_src_o));

    a_r5_upper_kept: assert property (@(posedge clk) disable iff (rst)
        (done_i && !load_en && mode_i != 2'b00) |=>
            (count_o[CNT_W-1:HALF_W] == $past(count_o[CNT_W-1:HALF_W]) && !end_o && !clr_en_o));

    a_r6_chain_alone: assert property (@(posedge clk) disable iff (rst)
        chain_o |-> (!end_o && !irq_o && !clr_src_o && !clr_en_o));

    a_r8_clear_or_irq: assert property (@(posedge clk) disable iff (rst)
        clr_src_o |-> !irq_o);

    a_r10_after_done: assert property (@(posedge clk) disable iff (rst)
        (end_o || irq_o || clr_src_o || clr_en_o || chain_o || addr_err_o) |-> $past(done_i));
endmodule

bind xfer_count_ctrl xcc_checker #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .load_en    (load_en),
    .load_count (load_count),
    .mode_i     (mode_i),
    .done_i     (done_i),
    .count_o    (count_o),
    .end_o      (end_o),
    .irq_o      (irq_o),
    .clr_src_o  (clr_src_o),
    .clr_en_o   (clr_en_o),
    .chain_o    (chain_o),
    .addr_err_o (addr_err_o)
);

// File: tb/xfer_count_ctrl_test.sv
module xfer_count_ctrl_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        load_en;
    logic [15:0] load_count;
    logic [1:0]  mode_i;
    logic        chain_en;
    logic        irq_sel;
    logic        word_size;
    logic [23:0] src_addr;
    logic [23:0] dst_addr;
    logic        done_i;
    logic [15:0] count_o;
    logic        end_o, irq_o, clr_src_o, clr_en_o, chain_o, addr_err_o;

    int checks = 0;
    int errors = 0;
    logic [15:0] m_count = 16'h0;
    bit finished = 0;

    always #2 clk = ~clk;

    xfer_count_ctrl uut (
        .clk(clk), .rst(rst), .load_en(load_en), .load_count(load_count),
        .mode_i(mode_i), .chain_en(chain_en), .irq_sel(irq_sel),
        .word_size(word_size), .src_addr(src_addr), .dst_addr(dst_addr),
        .done_i(done_i), .count_o(count_o), .end_o(end_o), .irq_o(irq_o),
        .clr_src_o(clr_src_o), .clr_en_o(clr_en_o), .chain_o(chain_o),
        .addr_err_o(addr_err_o)
    );

    function automatic logic [15:0] exp_count(logic [15:0] c, logic [1:0] md,
                                              logic dn, logic ld, logic [15:0] lv);
        logic [7:0] lo;
        if (ld) return lv;
        if (!dn) return c;
        if (md == 2'b00) return c - 16'd1;
        lo = c[7:0];
        if (lo == 8'd1) return {c[15:8], c[15:8]};
        return {c[15:8], lo - 8'd1};
    endfunction

    // order: end, irq, clr_src, clr_en, chain, addr_err
    function automatic logic [5:0] exp_pulses(logic [15:0] c, logic [1:0] md, logic dn,
                                              logic ch, logic is, logic ws,
                                              logic s0, logic d0);
        logic fin;
        logic [5:0] r;
        r = '0;
        if (dn) begin
            fin  = (md == 2'b00) && (c == 16'd1);
            r[0] = ws & (s0 | d0);
            if (ch) r[1] = 1'b1;
            else if (fin) begin r[5] = 1'b1; r[4] = 1'b1; r[2] = 1'b1; end
            else if (is) r[4] = 1'b1;
            else r[3] = 1'b1;
        end
        return r;
    endfunction

    task automatic check(string tag, logic [15:0] act, logic [15:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    task automatic step(logic ld, logic [15:0] lv, logic [1:0] md, logic ch, logic is,
                        logic ws, logic [23:0] sa, logic [23:0] da, logic dn);
        logic [15:0] ec;
        logic [5:0]  ep;
        string       tag;
        load_en = ld; load_count = lv; mode_i = md; chain_en = ch; irq_sel = is;
        word_size = ws; src_addr = sa; dst_addr = da; done_i = dn;
        ec = exp_count(m_count, md, dn, ld, lv);
        ep = exp_pulses(m_count, md, dn, ch, is, ws, sa[0], da[0]);
        if (!dn) tag = "R10";
        else if (ch) tag = "R6";
        else if (md == 2'b00 && m_count == 16'd1) tag = "R4";
        else if (md != 2'b00) tag = "R5";
        else if (is) tag = "R7";
        else tag = "R8";
        @(posedge clk);
        @(negedge clk);
        check(ld ? "R2 count" : (md == 2'b00 ? "R3 count" : "R5 count"), count_o, ec);
        check({tag, " pulses"}, {10'b0, end_o, irq_o, clr_src_o, clr_en_o, chain_o, 1'b0},
              {10'b0, ep[5:1], 1'b0});
        check("R9 addr_err", {15'b0, addr_err_o}, {15'b0, ep[0]});
        m_count = ec;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(190000 * 4);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        rst = 1'b1; load_en = 0; load_count = 0; mode_i = 0; chain_en = 0; irq_sel = 0;
        word_size = 0; src_addr = 0; dst_addr = 0; done_i = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0; done_i = 0;
        // R1: reset state
        check("R1 count", count_o, 16'h0);
        check("R1 pulses", {10'b0, end_o, irq_o, clr_src_o, clr_en_o, chain_o, addr_err_o}, 16'h0);

        // R3 wrap of zero, R2 load beats simultaneous strobe
        step(0, 0, 2'b00, 0, 0, 0, 0, 0, 1);
        step(1, 16'd1, 2'b00, 0, 1, 0, 0, 0, 1);
        // R6 chain at count 1: no end
        step(0, 0, 2'b00, 1, 0, 0, 0, 0, 1);
        // R4 end with interrupt-select both ways
        step(1, 16'd1, 2'b00, 0, 0, 0, 0, 0, 0);
        step(0, 0, 2'b00, 0, 0, 0, 0, 0, 1);
        step(1, 16'd1, 2'b00, 0, 1, 0, 0, 0, 0);
        step(0, 0, 2'b00, 0, 1, 0, 0, 0, 1);
        step(0, 0, 2'b00, 0, 0, 0, 0, 0, 0);
        // R5 split: lower byte through 1 and 0
        step(1, 16'h0302, 2'b01, 0, 0, 0, 0, 0, 0);
        step(0, 0, 2'b01, 0, 0, 0, 0, 0, 1);
        step(0, 0, 2'b01, 0, 1, 0, 0, 0, 1);
        step(1, 16'h0500, 2'b10, 0, 0, 0, 0, 0, 0);
        step(0, 0, 2'b10, 0, 0, 0, 0, 0, 1);
        step(1, 16'h0001, 2'b11, 0, 0, 0, 0, 0, 0);
        step(0, 0, 2'b11, 0, 0, 0, 0, 0, 1);
        // R9 alignment corners
        step(0, 0, 2'b00, 0, 0, 1, 24'h000001, 24'h000002, 1);
        step(0, 0, 2'b00, 1, 0, 1, 24'h000010, 24'hFFFFFF, 1);
        step(0, 0, 2'b00, 0, 0, 0, 24'h000003, 24'h000005, 1);
        step(0, 0, 2'b00, 0, 0, 1, 24'h000003, 24'h000005, 0);

        // R4: zero loaded means 65,536 transfers
        step(1, 16'h0000, 2'b00, 0, 0, 0, 0, 0, 0);
        for (int i = 0; i < 65536; i++) begin
            step(0, 0, 2'b00, 0, 0, 0, 0, 0, 1);
        end
        check("R4 count after 65536", count_o, 16'h0000);
        check("R4 end seen at 65536", {15'b0, end_o}, 16'h0001);

        // random mix
        for (int i = 0; i < 4000; i++) begin
            logic [15:0] lv;
            logic [1:0]  md;
            logic        ld;
            md = ($urandom_range(0, 2) == 0) ? 2'($urandom) : 2'b00;
            ld = ($urandom_range(0, 5) == 0);
            lv = ($urandom_range(0, 1) == 0) ? 16'($urandom_range(0, 4)) :
                 {8'($urandom_range(0, 4)), 8'($urandom_range(0, 3))};
            step(ld, lv, md, ($urandom_range(0, 4) == 0), 1'($urandom), 1'($urandom),
                 24'($urandom), 24'($urandom), ($urandom_range(0, 3) != 0));
        end
        finish_run();
    end
endmodule